// File: doc/BRIEF.md
# Key Matrix Scan Encoder

This block walks an 8 by 8 key matrix one row at a time and turns the first pressed key it finds into a single byte. While it drives a row it reads the column sense lines back. It keeps each row driven for a set number of clocks so that the lines can settle, then samples them. It scans rows upward from row 0. The first row with any column active ends the pass. In that row the lowest active column is the key taken.

The byte it reports holds the column index and the row index of the key. Two modifier flags are merged in at the moment the key is found. A new byte reaches the output register only when two consecutive passes produce the same byte, which is a simple debounce. A pass that finds nothing raises the empty flag. A status byte tells a host whether a key is waiting.

Top module: `kbd_matrix_encoder`

## Requirements
- R1: Exactly one bit of `row_drive` is high at any time (active high, bit n drives row n). Row 0 is driven first, the rows advance in ascending order, and each row is held for SETTLE clocks (default 4) before its columns are sampled.
- R2: A pass ends at the first sampled row that has any column sense bit high, so a lower-numbered row wins over a higher one. Within that row the lowest-numbered high column is the one encoded.
- R3: In the code byte, bits 2:0 carry the column index and bits 5:3 carry the row index of the encoded key.
- R4: `mod_in[0]` is active low: when it is 0 at the sample that finds the key, code bit 7 is 1, otherwise bit 7 is 0.
- R5: `mod_in[1]` is active high: when it is 1 at the sample that finds the key, code bit 6 is 1, otherwise bit 6 is 0.
- R6: A pass over all 8 rows that finds no key sets `key_empty` in the next cycle, whatever the modifiers are, and leaves `key_code` unchanged.
- R7: `key_status` reads 8'h40 while `key_empty` is 0 and 8'h00 while it is 1.
- R8: `key_code` changes, and `key_empty` clears, only at the end of a pass whose code equals the code of the pass just before it. A pass with no key breaks the chain.
- R9: A synchronous active-high `rst` clears `key_code` to 8'h00, sets `key_empty`, and restarts the scan at row 0 with no earlier pass remembered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| col_sense | input | 8 | Column lines for the row being driven, 1 = key closed |
| mod_in | input | 2 | Modifiers: bit 0 Shift (active low), bit 1 Ctrl (active high) |
| row_drive | output | 8 | One-hot row select, active high |
| key_code | output | 8 | Registered key code |
| key_empty | output | 1 | 1 when no key is held in the code register |
| key_status | output | 8 | 8'h40 when a key is available, 8'h00 when empty |

## Verification
The assertions check on every cycle that the row select stays one-hot and moves only at sample points, in ascending order. They also check that the code register stays put unless a pass confirms a repeated code, that a pass with no key leads to the empty state, and that a confirmation loads the row field and a ready status. Only the bench scenarios can show the encoding: which of two pressed keys wins, the exact column and modifier bits, the two-pass delay before the first code appears, and the behaviour when keys change between passes. These come from a behavioural reference that is compared with the outputs on every clock.

// File: rtl/kbd_scan_pkg.sv
package kbd_scan_pkg;
  localparam int ROWS   = 8;
  localparam int COLS   = 8;
  localparam int ROW_W  = $clog2(ROWS);
  localparam int COL_W  = $clog2(COLS);
  localparam int CODE_W = 8;
  localparam logic [CODE_W-1:0] STATUS_READY = 8'h40;
  localparam logic [CODE_W-1:0] STATUS_IDLE  = 8'h00;

  // Index of the lowest high bit; 0 when none is set.
  function automatic logic [COL_W-1:0] lowest_col(input logic [COLS-1:0] bits);
    logic [COL_W-1:0] res;
    res = '0;
    for (int i = COLS - 1; i >= 0; i--) begin
      if (bits[i]) res = COL_W'(i);
    end
    return res;
  endfunction

  // Shift flag from active-low mods[0], Ctrl flag from active-high mods[1].
  function automatic logic [CODE_W-1:0] pack_code(input logic [ROW_W-1:0] row,
                                                  input logic [COL_W-1:0] col,
                                                  input logic [1:0]       mods);
    return {~mods[0], mods[1], row, col};
  endfunction
endpackage

// File: rtl/kbd_row_scanner.sv
module kbd_row_scanner
  import kbd_scan_pkg::*;
#(
  parameter int SETTLE = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             row_hit,
  output logic [ROW_W-1:0] row_idx,
  output logic [ROWS-1:0]  row_drive,
  output logic             sample_evt,
  output logic             pass_end
);
  localparam int CW = (SETTLE > 1) ? $clog2(SETTLE) : 1;
  localparam logic [CW-1:0]    CNT_LAST = CW'(SETTLE - 1);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

  logic [CW-1:0] settle_cnt;
  logic          last_row;

  assign sample_evt = (settle_cnt == CNT_LAST);
  assign last_row   = (row_idx == ROW_LAST);
  assign pass_end   = sample_evt && (row_hit || last_row);

  always_ff @(posedge clk) begin
    if (rst) begin
      settle_cnt <= '0;
      row_idx    <= '0;
    end else if (sample_evt) begin
      settle_cnt <= '0;
      if (pass_end) row_idx <= '0;
      else          row_idx <= row_idx + 1'b1;
    end else begin
      settle_cnt <= settle_cnt + 1'b1;
    end
  end

  for (genvar g = 0; g < ROWS; g++) begin : g_row
    assign row_drive[g] = (row_idx == ROW_W'(g));
  end

  AST_ONE_ROW: assert property (@(posedge clk) disable iff (rst)
    $countones(row_drive) == 1); // R1
  AST_ROW_HOLD: assert property (@(posedge clk) disable iff (rst)
    !sample_evt |=> $stable(row_idx)); // R1
  AST_ROW_ORDER: assert property (@(posedge clk) disable iff (rst)
    (sample_evt && !row_hit && !last_row) |=> (row_idx == $past(row_idx) + 1'b1)); // R1
  AST_PASS_RESTART: assert property (@(posedge clk) disable iff (rst)
    (sample_evt && row_hit) |=> (row_idx == '0)); // R2
endmodule

// File: rtl/kbd_row_encoder.sv
module kbd_row_encoder
  import kbd_scan_pkg::*;
(
  input  logic [ROW_W-1:0]  row_idx,
  input  logic [COLS-1:0]   col_sense,
  input  logic [1:0]        mod_in,
  output logic              row_hit,
  output logic [CODE_W-1:0] cand_code
);
  assign row_hit   = |col_sense;
  assign cand_code = pack_code(row_idx, lowest_col(col_sense), mod_in);
endmodule

// File: rtl/kbd_debounce_reg.sv
module kbd_debounce_reg
  import kbd_scan_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              pass_end,
  input  logic              row_hit,
  input  logic [CODE_W-1:0] cand_code,
  output logic              commit,
  output logic [CODE_W-1:0] key_code,
  output logic              key_empty
);
  logic              prev_valid;
  logic [CODE_W-1:0] prev_code;
  logic              pass_none;

  assign pass_none = pass_end && !row_hit;
  assign commit    = pass_end && row_hit && prev_valid && (prev_code == cand_code);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_valid <= 1'b0;
      prev_code  <= '0;
      key_code   <= '0;
      key_empty  <= 1'b1;
    end else if (pass_end) begin
      if (row_hit) begin
        prev_valid <= 1'b1;
        prev_code  <= cand_code;
        if (commit) begin
          key_code  <= cand_code;
          key_empty <= 1'b0;
        end
      end else begin
        prev_valid <= 1'b0;
        key_empty  <= 1'b1;
      end
    end
  end

  AST_HOLD_CODE: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(key_code)); // R8
  AST_NONE_EMPTY: assert property (@(posedge clk) disable iff (rst)
    pass_none |=> key_empty); // R6
  AST_EMPTY_ONLY_ON_PASS: assert property (@(posedge clk) disable iff (rst)
    (!pass_end && key_empty) |=> key_empty); // R8
endmodule

// File: rtl/kbd_matrix_encoder.sv
module kbd_matrix_encoder
  import kbd_scan_pkg::*;
#(
  parameter int SETTLE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [COLS-1:0]   col_sense,
  input  logic [1:0]        mod_in,
  output logic [ROWS-1:0]   row_drive,
  output logic [CODE_W-1:0] key_code,
  output logic              key_empty,
  output logic [CODE_W-1:0] key_status
);
  logic [ROW_W-1:0]  row_idx;
  logic              row_hit;
  logic              sample_evt;
  logic              pass_end;
  logic              commit;
  logic [CODE_W-1:0] cand_code;

  kbd_row_scanner #(.SETTLE(SETTLE)) u_scan (
    .clk        (clk),
    .rst        (rst),
    .row_hit    (row_hit),
    .row_idx    (row_idx),
    .row_drive  (row_drive),
    .sample_evt (sample_evt),
    .pass_end   (pass_end)
  );

  kbd_row_encoder u_enc (
    .row_idx   (row_idx),
    .col_sense (col_sense),
    .mod_in    (mod_in),
    .row_hit   (row_hit),
    .cand_code (cand_code)
  );

  kbd_debounce_reg u_deb (
    .clk       (clk),
    .rst       (rst),
    .pass_end  (pass_end),
    .row_hit   (row_hit),
    .cand_code (cand_code),
    .commit    (commit),
    .key_code  (key_code),
    .key_empty (key_empty)
  );

  assign key_status = key_empty ? STATUS_IDLE : STATUS_READY;

  AST_COMMIT_READY: assert property (@(posedge clk) disable iff (rst)
    commit |=> (!key_empty && key_status == STATUS_READY)); // R7
  AST_CODE_ROW: assert property (@(posedge clk) disable iff (rst)
    commit |=> (key_code[5:3] == $past(row_idx))); // R3
  AST_EMPTY_STATUS: assert property (@(posedge clk) disable iff (rst)
    (pass_end && !row_hit) |=> (key_status == STATUS_IDLE)); // R7
endmodule

// File: tb/kbd_matrix_encoder_test.sv
module kbd_matrix_encoder_test;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 4;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] col_sense;
  logic [1:0] mod_in = 2'b01;
  logic [7:0] row_drive;
  logic [7:0] key_code;
  logic       key_empty;
  logic [7:0] key_status;

  logic [7:0] mat [8];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  kbd_matrix_encoder #(.SETTLE(SETTLE)) uut (
    .clk(clk), .rst(rst), .col_sense(col_sense), .mod_in(mod_in),
    .row_drive(row_drive), .key_code(key_code), .key_empty(key_empty),
    .key_status(key_status)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Matrix wiring: a closed key connects its row line to its column line.
  always_comb begin
    col_sense = 8'h00;
    for (int r = 0; r < 8; r++) if (row_drive[r]) col_sense = col_sense | mat[r];
  end

  // Behavioural reference
  int m_row, m_cnt, m_code, m_prev;
  bit m_empty, m_prev_v;
  always @(posedge clk) begin
    if (rst) begin
      m_row = 0; m_cnt = 0; m_code = 0; m_empty = 1; m_prev_v = 0; m_prev = 0;
    end else if (m_cnt < SETTLE - 1) begin
      m_cnt++;
    end else begin
      int col;
      m_cnt = 0;
      col = -1;
      for (int c = 7; c >= 0; c--) if (mat[m_row][c]) col = c;
      if (col >= 0) begin
        int code;
        code = col + 8 * m_row + (mod_in[1] ? 64 : 0) + (mod_in[0] ? 0 : 128);
        if (m_prev_v && m_prev == code) begin
          m_code = code; m_empty = 0;
        end
        m_prev_v = 1; m_prev = code; m_row = 0;
      end else if (m_row == 7) begin
        m_empty = 1; m_prev_v = 0; m_row = 0;
      end else begin
        m_row++;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R1 row_drive", row_drive, 1 << m_row);
      check("R3 key_code", key_code, m_code);
      check("R6 key_empty", key_empty, m_empty);
      check("R7 key_status", key_status, m_empty ? 0 : 'h40);
    end
  end

  task automatic clear_keys();
    for (int r = 0; r < 8; r++) mat[r] = 8'h00;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    clear_keys();
    do_reset();
    check("R9 reset code", key_code, 8'h00);
    check("R9 reset empty", key_empty, 1);
    check("R9 reset status", key_status, 8'h00);
    check("R9 reset row", row_drive, 8'h01);

    // R1: row 0 held SETTLE clocks, then row 1
    wait_cycles(SETTLE - 1);
    check("R1 row held", row_drive, 8'h01);
    wait_cycles(1);
    check("R1 row advance", row_drive, 8'h02);

    // R8: first pass alone does not load; second identical pass does
    mat[0] = 8'h08; mod_in = 2'b01;
    do_reset();
    wait_cycles(SETTLE);
    check("R8 one pass still empty", key_empty, 1);
    wait_cycles(SETTLE);
    check("R8 two passes load", key_code, 8'h03);
    check("R8 two passes ready", key_empty, 0);

    // R3/R7: row 2 col 5, no modifiers
    clear_keys(); mat[2] = 8'h20; mod_in = 2'b01;
    wait_cycles(100);
    check("R3 row2 col5", key_code, 8'h15);
    check("R7 status ready", key_status, 8'h40);

    // R4: Shift (active low)
    mod_in = 2'b00;
    wait_cycles(100);
    check("R4 shift", key_code, 8'h95);

    // R5: Ctrl (active high)
    mod_in = 2'b11;
    wait_cycles(100);
    check("R5 ctrl", key_code, 8'h55);

    // R2: lower row wins, lowest column within a row wins
    mod_in = 2'b01; clear_keys(); mat[3] = 8'h02; mat[6] = 8'h01;
    wait_cycles(100);
    check("R2 lower row", key_code, 8'h19);
    clear_keys(); mat[5] = 8'h50;
    wait_cycles(100);
    check("R2 lowest column", key_code, 8'h2C);

    // R6: release sets empty, code retained; modifiers alone give nothing
    clear_keys(); mod_in = 2'b10;
    wait_cycles(100);
    check("R6 release empty", key_empty, 1);
    check("R6 code kept", key_code, 8'h2C);
    check("R7 status idle", key_status, 8'h00);

    // R8: key alternating between passes never confirms
    for (int i = 0; i < 6; i++) begin
      clear_keys();
      mat[1] = (i % 2 == 0) ? 8'h01 : 8'h02;
      wait_cycles(2 * SETTLE);
    end
    check("R8 alternating stays empty", key_empty, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule